// File: doc/BRIEF.md
# Hysteretic On/Off Link Flow Control

This block models one point-to-point flit link whose receiver throttles the sender with a single stop/go wire instead of a count of free slots. The sender side takes a flit whenever it has one and the go wire, as seen after its return delay, is not in the stop state. Taken flits travel through a fixed-latency forward path into the receiver FIFO. The FIFO is drained by a downstream consumer.

The receiver watches its own fill level. It raises stop once the level has climbed to an upper mark. It holds stop until the level has fallen to a lower mark. The gap between the two marks keeps the wire from toggling on every flit.

The upper mark is placed low enough that every flit already launched before the sender notices stop still finds a free slot. The lower mark is placed high enough that a consumer draining every cycle still has flits left when the first newly released flit lands. The forward delay, the return delay and both marks are parameters.

Top module: `onoff_link`

## Requirements
- R1: While rstN is low and in the first cycle after it rises, level is 0, sinkValid is 0, rxOff is 0 and txOff is 0.
- R2: In every cycle, srcTake is 1 exactly when srcValid is 1 and txOff is 0. The sender takes no flit in a cycle where it sees txOff high, and it resumes in the first cycle where txOff is low.
- R3: A flit taken in cycle t is written into the FIFO in cycle t+FWD_DLY and counts in level from cycle t+FWD_DLY+1. Flits leave on sinkData in the order they were taken, each exactly once.
- R4: If level is at least OFF_TH in a cycle, rxOff is 1 in the next cycle.
- R5: rxOff falls in the cycle after level is at most ON_TH. It stays 1 while level is above ON_TH. Once low, it stays 0 while level is below OFF_TH. ON_TH must be lower than OFF_TH.
- R6: txOff equals rxOff delayed by BWD_DLY cycles.
- R7: With OFF_TH no greater than DEPTH-(FWD_DLY+BWD_DLY+1), level never exceeds DEPTH and no flit is lost. With a stalled consumer and a sender that always has flits, the peak level is exactly OFF_TH+FWD_DLY+BWD_DLY+1.
- R8: With ON_TH at least FWD_DLY+BWD_DLY+2, a sender that always has flits and a consumer that is always ready, sinkValid never drops to 0 once the FIFO holds a flit.
- R9: sinkValid is 1 exactly when level is nonzero, and a flit is removed in each cycle where sinkValid and sinkReady are both 1. sinkData shows the oldest stored flit. level changes by at most one per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| srcValid | input | 1 | Sender holds a flit ready to launch |
| srcData | input | DATA_W | Payload of the offered flit |
| srcTake | output | 1 | Offered flit is launched this cycle |
| txOff | output | 1 | Stop signal as observed at the sender |
| rxOff | output | 1 | Stop signal as driven by the receiver |
| level | output | $clog2(DEPTH+1) | Receiver FIFO fill level |
| sinkReady | input | 1 | Consumer accepts a flit this cycle |
| sinkValid | output | 1 | FIFO has a flit for the consumer |
| sinkData | output | DATA_W | Oldest stored flit |

## Verification
The properties assume the two marks satisfy the placement limits of R7 and R8, with ON_TH below OFF_TH. They also assume both delays are at least one cycle. They place no limit on how srcValid and sinkReady move.

The stimulus keeps to the default marks, which sit exactly on both limits. It then exercises them with a stalled consumer, a fully streaming link, a resume from full, pseudo-random offer and drain patterns, and a final drain. That mix pushes the level to its worst-case peak and to its lowest point after a release.

// File: rtl/onoff_pkg.sv
package onoff_pkg;
  // Strobes from the control side to the datapath side
  typedef struct packed {
    logic take;  // sender launches srcData into the forward path
    logic push;  // forward path head is written into the FIFO
    logic pop;   // FIFO head is handed to the consumer
  } linkStrobe_t;
endpackage

// File: rtl/onoff_ctrl.sv
module onoff_ctrl
  import onoff_pkg::*;
#(
  parameter int DEPTH   = 16,
  parameter int BWD_DLY = 2,
  parameter int OFF_TH  = 11,
  parameter int ON_TH   = 6,
  parameter int LVL_W   = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             srcValid,
  input  logic             sinkReady,
  input  logic             arrValid,
  output linkStrobe_t      strb,
  output logic [LVL_W-1:0] level,
  output logic             rxOff,
  output logic             txOff,
  output logic             sinkValid
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] OFF_LVL  = LVL_W'(OFF_TH);
  localparam logic [LVL_W-1:0] ON_LVL   = LVL_W'(ON_TH);

  logic [LVL_W-1:0]   levelQ;
  logic               rxOffQ;
  logic [BWD_DLY-1:0] backPipe;

  assign level     = levelQ;
  assign rxOff     = rxOffQ;
  assign txOff     = backPipe[BWD_DLY-1];
  assign sinkValid = (levelQ != '0);

  always_comb begin
    strb.take = srcValid && !backPipe[BWD_DLY-1];
    strb.pop  = sinkReady && (levelQ != '0);
    strb.push = arrValid && ((levelQ != FULL_LVL) || strb.pop);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      levelQ <= '0;
    end else begin
      case ({strb.push, strb.pop})
        2'b10:   levelQ <= levelQ + 1'b1;
        2'b01:   levelQ <= levelQ - 1'b1;
        default: levelQ <= levelQ;
      endcase
    end
  end

  // hysteretic stop signal
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rxOffQ <= 1'b0;
    end else if (levelQ >= OFF_LVL) begin
      rxOffQ <= 1'b1;
    end else if (levelQ <= ON_LVL) begin
      rxOffQ <= 1'b0;
    end
  end

  // return path delay of the stop signal
  generate
    if (BWD_DLY == 1) begin : g_back1
      always_ff @(posedge clk) begin
        if (!rstN) backPipe <= '0;
        else       backPipe <= rxOffQ;
      end
    end else begin : g_backN
      always_ff @(posedge clk) begin
        if (!rstN) backPipe <= '0;
        else       backPipe <= {backPipe[BWD_DLY-2:0], rxOffQ};
      end
    end
  endgenerate
endmodule

// File: rtl/onoff_dp.sv
module onoff_dp
  import onoff_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 16,
  parameter int FWD_DLY = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  linkStrobe_t       strb,
  input  logic [DATA_W-1:0] srcData,
  output logic              arrValid,
  output logic [DATA_W-1:0] sinkData
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

  logic [FWD_DLY-1:0] fwdVld;
  logic [DATA_W-1:0]  fwdDat [FWD_DLY];
  logic [DATA_W-1:0]  mem    [DEPTH];
  logic [PTR_W-1:0]   wrPtr;
  logic [PTR_W-1:0]   rdPtr;

  // forward wire delay, one register per stage
  generate
    for (genvar s = 0; s < FWD_DLY; s++) begin : g_fwd
      if (s == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rstN) fwdVld[0] <= 1'b0;
          else       fwdVld[0] <= strb.take;
          fwdDat[0] <= srcData;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rstN) fwdVld[s] <= 1'b0;
          else       fwdVld[s] <= fwdVld[s-1];
          fwdDat[s] <= fwdDat[s-1];
        end
      end
    end
  endgenerate

  assign arrValid = fwdVld[FWD_DLY-1];
  assign sinkData = mem[rdPtr];

  always_ff @(posedge clk) begin
    if (strb.push) mem[wrPtr] <= fwdDat[FWD_DLY-1];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (strb.push) wrPtr <= (wrPtr == LAST_PTR) ? '0 : wrPtr + 1'b1;
      if (strb.pop)  rdPtr <= (rdPtr == LAST_PTR) ? '0 : rdPtr + 1'b1;
    end
  end
endmodule

// File: rtl/onoff_link.sv
module onoff_link
  import onoff_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DEPTH   = 16,
  parameter int FWD_DLY = 2,
  parameter int BWD_DLY = 2,
  parameter int OFF_TH  = DEPTH - (FWD_DLY + BWD_DLY + 1),
  parameter int ON_TH   = FWD_DLY + BWD_DLY + 2
) (
  input  logic                         clk,
  input  logic                         rstN,
  input  logic                         srcValid,
  input  logic [DATA_W-1:0]            srcData,
  output logic                         srcTake,
  output logic                         txOff,
  output logic                         rxOff,
  output logic [$clog2(DEPTH+1)-1:0]   level,
  input  logic                         sinkReady,
  output logic                         sinkValid,
  output logic [DATA_W-1:0]            sinkData
);
  localparam int LVL_W = $clog2(DEPTH + 1);

  linkStrobe_t strb;
  logic        arrValid;

  assign srcTake = strb.take;

  onoff_ctrl #(
    .DEPTH(DEPTH), .BWD_DLY(BWD_DLY), .OFF_TH(OFF_TH), .ON_TH(ON_TH), .LVL_W(LVL_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .sinkReady(sinkReady),
    .arrValid(arrValid), .strb(strb), .level(level), .rxOff(rxOff),
    .txOff(txOff), .sinkValid(sinkValid)
  );

  onoff_dp #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .FWD_DLY(FWD_DLY)
  ) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .srcData(srcData),
    .arrValid(arrValid), .sinkData(sinkData)
  );
endmodule

// File: rtl/onoff_link_chk.sv
module onoff_link_chk #(
  parameter int DEPTH  = 16,
  parameter int OFF_TH = 11,
  parameter int ON_TH  = 6,
  parameter int LVL_W  = 5
) (
  input logic             clk,
  input logic             rstN,
  input logic             srcValid,
  input logic             srcTake,
  input logic             txOff,
  input logic             rxOff,
  input logic [LVL_W-1:0] level,
  input logic             sinkReady,
  input logic             sinkValid
);
  localparam logic [LVL_W-1:0] FULL_LVL = LVL_W'(DEPTH);
  localparam logic [LVL_W-1:0] OFF_LVL  = LVL_W'(OFF_TH);
  localparam logic [LVL_W-1:0] ON_LVL   = LVL_W'(ON_TH);

  // R7
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rstN)
    level <= FULL_LVL);

  // R4
  off_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (level >= OFF_LVL) |=> rxOff);

  // R5
  off_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rxOff && level > ON_LVL) |=> rxOff);

  // R5
  on_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    (level <= ON_LVL) |=> !rxOff);

  // R5
  off_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!rxOff && level < OFF_LVL) |=> !rxOff);

  // R2
  gate_stop_chk: assert property (@(posedge clk) disable iff (!rstN)
    txOff |-> !srcTake);

  // R2
  gate_pass_chk: assert property (@(posedge clk) disable iff (!rstN)
    (srcValid && !txOff) |-> srcTake);

  // R9
  pop_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sinkValid && sinkReady) |=> (level <= $past(level)));

  // R9
  level_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (level <= $past(level) + 1'b1) && (level + 1'b1 >= $past(level)));
endmodule

bind onoff_link onoff_link_chk #(
  .DEPTH(DEPTH), .OFF_TH(OFF_TH), .ON_TH(ON_TH), .LVL_W($clog2(DEPTH+1))
) u_chk (
  .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcTake(srcTake),
  .txOff(txOff), .rxOff(rxOff), .level(level), .sinkReady(sinkReady),
  .sinkValid(sinkValid)
);

// File: tb/onoff_link_bench.sv
module onoff_link_bench;
  localparam int DATA_W  = 8;
  localparam int DEPTH   = 16;
  localparam int FWD_DLY = 2;
  localparam int BWD_DLY = 2;
  localparam int OFF_TH  = DEPTH - (FWD_DLY + BWD_DLY + 1);
  localparam int ON_TH   = FWD_DLY + BWD_DLY + 2;
  localparam int LVL_W   = $clog2(DEPTH + 1);

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              srcValid = 1'b0;
  logic [DATA_W-1:0] srcData = '0;
  logic              srcTake, txOff, rxOff, sinkValid;
  logic [LVL_W-1:0]  level;
  logic              sinkReady = 1'b0;
  logic [DATA_W-1:0] sinkData;

  always #10 clk = ~clk;  // 50 MHz

  onoff_link #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .FWD_DLY(FWD_DLY), .BWD_DLY(BWD_DLY),
    .OFF_TH(OFF_TH), .ON_TH(ON_TH)
  ) u_onoff_link (
    .clk(clk), .rstN(rstN), .srcValid(srcValid), .srcData(srcData),
    .srcTake(srcTake), .txOff(txOff), .rxOff(rxOff), .level(level),
    .sinkReady(sinkReady), .sinkValid(sinkValid), .sinkData(sinkData)
  );

  int nCompared = 0;
  int nMismatch = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nCompared++;
    if (!ok) begin
      nMismatch++;
      $display("FAIL %s: actual %0d expected %0d at %0t", req, act, exp, $time);
    end
  endtask

  // scoreboard
  logic [DATA_W-1:0] expQ[$];
  logic [DATA_W-1:0] nextData = 8'h01;

  // reference state per requirement timing
  int  mLevel = 0;
  bit  mRx = 0;
  bit  mBwd[BWD_DLY];
  bit  mFwd[FWD_DLY];
  int  phase = 0;
  int  peakLevel = 0;
  bit  sawRelease = 0;
  bit  starved = 0;

  // monitor at the falling edge
  always @(negedge clk) begin
    if (!rstN) begin
      // R1
      chk(level == 0, "R1 level in reset", int'(level), 0);
      chk(!sinkValid && !rxOff && !txOff, "R1 flags in reset",
          int'({sinkValid, rxOff, txOff}), 0);
    end else begin
      bit mTx, mTake, mPop, mPush, arr, newRx;
      mTx = mBwd[BWD_DLY-1];
      arr = mFwd[FWD_DLY-1];
      mTake = srcValid && !mTx;
      mPop = sinkReady && (mLevel != 0);
      mPush = arr && ((mLevel != DEPTH) || mPop);
      // R2
      chk(srcTake == mTake, "R2 sender gate", int'(srcTake), int'(mTake));
      // R6
      chk(txOff == mTx, "R6 delayed stop", int'(txOff), int'(mTx));
      // R4 R5
      chk(rxOff == mRx, "R4/R5 receiver stop", int'(rxOff), int'(mRx));
      // R3 R9
      chk(int'(level) == mLevel, "R3 level timing", int'(level), mLevel);
      chk(sinkValid == (mLevel != 0), "R9 sinkValid", int'(sinkValid), int'(mLevel != 0));
      if (int'(level) > peakLevel) peakLevel = int'(level);
      if (phase == 3 && !sinkValid) starved = 1;
      if (phase == 3 && !rxOff) sawRelease = 1;
      // scoreboard: R3 ordering
      if (srcTake) begin
        expQ.push_back(srcData);
        nextData = nextData + 1'b1;
      end
      if (sinkValid && sinkReady) begin
        if (expQ.size() == 0) begin
          chk(0, "R3 unexpected flit", int'(sinkData), -1);
        end else begin
          logic [DATA_W-1:0] e;
          e = expQ.pop_front();
          chk(sinkData == e, "R3 flit order", int'(sinkData), int'(e));
        end
      end
      // advance reference to the next cycle
      newRx = (mLevel >= OFF_TH) ? 1'b1 : (mLevel <= ON_TH) ? 1'b0 : mRx;
      for (int i = BWD_DLY - 1; i > 0; i--) mBwd[i] = mBwd[i-1];
      mBwd[0] = mRx;
      mRx = newRx;
      for (int i = FWD_DLY - 1; i > 0; i--) mFwd[i] = mFwd[i-1];
      mFwd[0] = mTake;
      mLevel = mLevel + int'(mPush) - int'(mPop);
    end
  end

  task automatic step(input bit v, input bit r);
    @(posedge clk);
    #2;
    srcValid = v;
    sinkReady = r;
    srcData = nextData;
  endtask

  logic [15:0] lfsr = 16'hACE1;

  initial begin
    for (int i = 0; i < BWD_DLY; i++) mBwd[i] = 0;
    for (int i = 0; i < FWD_DLY; i++) mFwd[i] = 0;
    repeat (4) @(posedge clk);
    #2 rstN = 1'b1;
    // phase 1: streaming
    phase = 1;
    repeat (30) step(1'b1, 1'b1);
    // phase 2: consumer stalled, fill to peak
    phase = 2;
    peakLevel = 0;
    repeat (40) step(1'b1, 1'b0);
    @(negedge clk);
    // R7
    chk(peakLevel == OFF_TH + FWD_DLY + BWD_DLY + 1, "R7 peak level",
        peakLevel, OFF_TH + FWD_DLY + BWD_DLY + 1);
    // phase 3: full drain with a sender that always has flits
    phase = 3;
    repeat (80) step(1'b1, 1'b1);
    @(negedge clk);
    // R8
    chk(!starved, "R8 no starvation", int'(starved), 0);
    // R5
    chk(sawRelease, "R5 stop released", int'(sawRelease), 1);
    // phase 4: pseudo-random offer and drain
    phase = 4;
    peakLevel = 0;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] | lfsr[3], lfsr[1] & (lfsr[5] | lfsr[7]));
    end
    @(negedge clk);
    // R7
    chk(peakLevel <= DEPTH, "R7 level bound", peakLevel, DEPTH);
    // phase 5: final drain
    phase = 5;
    repeat (40) step(1'b0, 1'b1);
    @(negedge clk);
    // R3
    chk(expQ.size() == 0, "R3 all flits delivered", expQ.size(), 0);
    // R9
    chk(!sinkValid && level == 0, "R9 empty after drain", int'(level), 0);
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
    $finish;
  end

  initial begin
    #(20 * 50000);
    if (!finished) begin
      nCompared++;
      nMismatch++;
      $display("FAIL watchdog: actual 0 expected 1 (run did not complete)");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCompared, nMismatch);
      $finish;
    end
  end
endmodule